// File: doc/BRIEF.md
# Bi-phase Serial Bus Word Transmitter

This block turns one 16-bit word into a 20-bit-time word on a redundant 1 Mbit/s serial bus. Each word starts with a three-bit-time sync pattern that is not bi-phase coded, and its polarity marks the word as a command/status word or a data word. Sixteen bi-phase data bits follow, most significant first, and then an odd parity bit. Words come in over a valid/ready handshake together with a type select and a bus select. The system clock runs at 12, 16, 20 or 24 MHz, and a 2-bit input tells the block which one.

Two buses are driven, and each has a complementary positive/negative pair and an inhibit line. The pair carries the serial level only while the chosen bus is enabled. At all other times both lines sit high and the inhibit is asserted. A watchdog shuts the transmitter down if it stays busy without a break for longer than a set number of microseconds. A loopback checker compares each finished word with the word an external receiver hands back in parallel, and flags any mismatch or any missing answer. Both flags are sticky until a clear input is pulsed.

Top module: `mbus_word_encoder`

## Requirements
- R1: Every half-bit lasts 6, 8, 10 or 12 clocks for `freq_sel` 0, 1, 2 or 3. A word is 40 half-bits long (20 bit times).
- R2: The sync occupies half-bits 0 to 5. A command/status word (`tx_is_cmd`=1) sends high for half-bits 0–2 and low for 3–5. A data word sends the inverse.
- R3: Data bit 15 goes out first, in half-bits 6 and 7, and bit 0 goes out last, in half-bits 36 and 37. A 1 is sent high then low, and a 0 low then high. Half-bits 38 and 39 carry an odd parity bit over the 16 data bits, coded the same way.
- R4: While no word is being sent, `*_p` and `*_n` of both buses are high and both inhibits are high.
- R5: `tx_bus_sel`=0 selects bus A and 1 selects bus B. The selected bus drives the level on `_p` and its complement on `_n`, with inhibit low, only while its enable input is high. The other bus stays idle.
- R6: `tx_ready` is high while the block is idle, and during the first cycle of the final (parity) bit time. It is low in the cycle before that. A word accepted during the final bit starts right after the current word, with no dead time.
- R7: After the block has been busy for SHUTDOWN_US microseconds without a break (SHUTDOWN_US × 2 × half-bit clocks), `tx_shutdown` rises. The buses then go idle with inhibits high and `tx_ready` stays low until `flag_clr` is pulsed.
- R8: A loopback word that equals the transmitted data and arrives within 4 µs (8 half-bit periods) after the end of the word leaves `lb_fail` low. This includes an arrival in the last cycle of that window.
- R9: `lb_fail` rises if the loopback word differs from the transmitted word, or if no loopback word arrives inside the window. `lb_fail` is sticky until `flag_clr`.
- R10: A loopback word presented while no window is open is ignored, and `lb_fail` stays unchanged.
- R11: After reset, `tx_ready` is high, every bus line and inhibit is high, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12/16/20/24 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_sel | input | 2 | Clock frequency code, 0=12 MHz … 3=24 MHz |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word can be taken |
| tx_data | input | 16 | Word to transmit |
| tx_is_cmd | input | 1 | 1: command/status sync, 0: data sync |
| tx_bus_sel | input | 1 | 0: bus A, 1: bus B |
| bus_a_en | input | 1 | Bus A transmit enable |
| bus_b_en | input | 1 | Bus B transmit enable |
| bus_a_p | output | 1 | Bus A positive line |
| bus_a_n | output | 1 | Bus A negative line |
| bus_a_inh | output | 1 | Bus A transmitter inhibit |
| bus_b_p | output | 1 | Bus B positive line |
| bus_b_n | output | 1 | Bus B negative line |
| bus_b_inh | output | 1 | Bus B transmitter inhibit |
| tx_shutdown | output | 1 | Continuous-transmit shutdown flag |
| lb_valid | input | 1 | Loopback word present |
| lb_data | input | 16 | Loopback word |
| lb_fail | output | 1 | Loopback failure flag |
| flag_clr | input | 1 | Clears both sticky flags |

## Verification
Several properties are checked by assertions on every cycle. The bus lines stay high whenever the shifter is idle, and any driven pair is complementary. Shutdown forces both inhibits high, and both flags stay set until cleared. A word taken during the final bit restarts the shifter at half-bit zero, and a flag can only rise after a busy period or an open window. The scenarios alone show the exact waveforms. These are the sync polarity, the bit order and the parity at every frequency, the position of the ready pulse, the exact cycle of the watchdog trip, and the loopback window boundary.

// File: rtl/mbenc_pkg.sv
package mbenc_pkg;
  localparam int WORD_BITS       = 16;
  localparam int HALVES_PER_WORD = 40;
  localparam int SYNC_HALVES     = 6;
  localparam int PARITY_HALF     = HALVES_PER_WORD - 2;

  // clocks per half bit time: 6, 8, 10, 12
  function automatic logic [3:0] half_clocks(input logic [1:0] sel);
    return 4'(6 + 2 * int'(sel));
  endfunction

  // clocks per microsecond: 12, 16, 20, 24
  function automatic logic [4:0] clocks_per_us(input logic [1:0] sel);
    return 5'(12 + 4 * int'(sel));
  endfunction

  function automatic logic odd_parity(input logic [WORD_BITS-1:0] d);
    return ~^d;
  endfunction

  // line level for half-bit idx of a word
  function automatic logic half_level(input logic [WORD_BITS-1:0] d,
                                      input logic is_cmd,
                                      input logic [5:0] idx);
    logic [5:0] k;
    logic [3:0] pos;
    logic       b;
    if (idx < 6'd3)                  return is_cmd;
    if (idx < 6'(SYNC_HALVES))       return ~is_cmd;
    if (idx >= 6'(PARITY_HALF))      b = odd_parity(d);
    else begin
      k   = idx - 6'(SYNC_HALVES);
      pos = 4'd15 - k[4:1];
      b   = d[pos];
    end
    return idx[0] ? ~b : b;
  endfunction
endpackage

// File: rtl/enc_halfbit_timer.sv
module enc_halfbit_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half_clks,
  output logic          half_end
);
  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == half_clks - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (half_end) cnt <= '0;
    else               cnt <= cnt + CW'(1);
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_clks));
endmodule

// File: rtl/enc_word_shifter.sv
module enc_word_shifter import mbenc_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_end,
  input  logic                 abort,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_BITS-1:0] in_data,
  input  logic                 in_cmd,
  input  logic                 in_bus,
  output logic                 busy,
  output logic                 level,
  output logic                 cur_bus,
  output logic [WORD_BITS-1:0] cur_data,
  output logic                 word_end
);
  localparam logic [5:0] LAST_HALF  = 6'(HALVES_PER_WORD - 1);
  localparam logic [5:0] FINAL_BIT0 = 6'(PARITY_HALF);

  logic [5:0]           idx;
  logic                 cur_cmd;
  logic                 pend_valid, pend_cmd, pend_bus;
  logic [WORD_BITS-1:0] pend_data;
  logic                 in_final_bit, accept;

  assign in_final_bit = busy && (idx >= FINAL_BIT0);
  assign in_ready     = !abort && (!busy || (in_final_bit && !pend_valid));
  assign accept       = in_valid && in_ready;
  assign word_end     = half_end && (idx == LAST_HALF);
  assign level        = half_level(cur_data, cur_cmd, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; cur_data <= '0; cur_cmd <= 1'b0; cur_bus <= 1'b0;
      pend_valid <= 1'b0; pend_data <= '0; pend_cmd <= 1'b0; pend_bus <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0; idx <= '0; pend_valid <= 1'b0;
    end else if (!busy) begin
      if (accept) begin
        busy <= 1'b1; idx <= '0;
        cur_data <= in_data; cur_cmd <= in_cmd; cur_bus <= in_bus;
      end
    end else if (word_end) begin
      idx <= '0;
      if (pend_valid) begin
        cur_data <= pend_data; cur_cmd <= pend_cmd; cur_bus <= pend_bus;
        pend_valid <= 1'b0;
      end else if (accept) begin
        cur_data <= in_data; cur_cmd <= in_cmd; cur_bus <= in_bus;
      end else begin
        busy <= 1'b0;
      end
    end else begin
      if (half_end) idx <= idx + 6'd1;
      if (accept) begin
        pend_valid <= 1'b1; pend_data <= in_data; pend_cmd <= in_cmd; pend_bus <= in_bus;
      end
    end
  end

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_HALF);
  // R6
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !abort && (pend_valid || accept)) |=> (busy && idx == 6'd0));
  // R6
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_ready) |-> (idx >= FINAL_BIT0));
endmodule

// File: rtl/enc_tx_watchdog.sv
module enc_tx_watchdog #(
  parameter int LIMIT_US = 690
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       clr,
  input  logic [4:0] cpu_clks,
  output logic       tripped
);
  localparam int CNT_W = $clog2(LIMIT_US * 24 + 2);

  logic [CNT_W-1:0] cnt, limit;
  logic             at_limit;

  assign limit    = CNT_W'(LIMIT_US) * CNT_W'(cpu_clks);
  assign at_limit = busy && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!busy)     cnt <= '0;
    else if (!at_limit) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tripped <= 1'b0;
    else if (clr)      tripped <= 1'b0;
    else if (at_limit) tripped <= 1'b1;
  end

  // R7
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !clr) |=> tripped);
  // R7
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(busy));
endmodule

// File: rtl/enc_loop_check.sv
module enc_loop_check import mbenc_pkg::*; #(
  parameter int WINDOW_US = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [WORD_BITS-1:0] arm_data,
  input  logic [4:0]           cpu_clks,
  input  logic                 lb_valid,
  input  logic [WORD_BITS-1:0] lb_data,
  input  logic                 clr,
  output logic                 fail
);
  localparam int TW = $clog2(WINDOW_US * 24 + 2);

  logic                 armed;
  logic [TW-1:0]        tmr, win;
  logic [WORD_BITS-1:0] expect_q;
  logic                 got_bad, got_none, fail_set;

  assign win      = TW'(WINDOW_US) * TW'(cpu_clks);
  assign got_bad  = armed && lb_valid && (lb_data != expect_q);
  assign got_none = armed && !lb_valid && (tmr == win - TW'(1));
  assign fail_set = !arm && (got_bad || got_none);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; tmr <= '0; expect_q <= '0;
    end else if (arm) begin
      armed <= 1'b1; tmr <= '0; expect_q <= arm_data;
    end else if (armed) begin
      if (lb_valid || got_none) armed <= 1'b0;
      else                      tmr <= tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail <= 1'b0;
    else if (clr)      fail <= 1'b0;
    else if (fail_set) fail <= 1'b1;
  end

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);
  // R10
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(armed));
endmodule

// File: rtl/mbus_word_encoder.sv
module mbus_word_encoder import mbenc_pkg::*; #(
  parameter int SHUTDOWN_US    = 690,
  parameter int LOOP_WINDOW_US = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           freq_sel,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [WORD_BITS-1:0] tx_data,
  input  logic                 tx_is_cmd,
  input  logic                 tx_bus_sel,
  input  logic                 bus_a_en,
  input  logic                 bus_b_en,
  output logic                 bus_a_p,
  output logic                 bus_a_n,
  output logic                 bus_a_inh,
  output logic                 bus_b_p,
  output logic                 bus_b_n,
  output logic                 bus_b_inh,
  output logic                 tx_shutdown,
  input  logic                 lb_valid,
  input  logic [WORD_BITS-1:0] lb_data,
  output logic                 lb_fail,
  input  logic                 flag_clr
);
  logic [3:0]           half_clks;
  logic [4:0]           cpu_clks;
  logic                 half_end, busy, level, cur_bus, word_end;
  logic [WORD_BITS-1:0] cur_data;
  logic                 drive_a, drive_b;

  assign half_clks = half_clocks(freq_sel);
  assign cpu_clks  = clocks_per_us(freq_sel);

  enc_halfbit_timer #(.CW(4)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_clks(half_clks), .half_end(half_end));

  enc_word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .half_end(half_end), .abort(tx_shutdown),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .in_cmd(tx_is_cmd), .in_bus(tx_bus_sel), .busy(busy), .level(level),
    .cur_bus(cur_bus), .cur_data(cur_data), .word_end(word_end));

  enc_tx_watchdog #(.LIMIT_US(SHUTDOWN_US)) u_wdog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clr(flag_clr),
    .cpu_clks(cpu_clks), .tripped(tx_shutdown));

  enc_loop_check #(.WINDOW_US(LOOP_WINDOW_US)) u_loop (
    .clk(clk), .rst_n(rst_n), .arm(word_end), .arm_data(cur_data),
    .cpu_clks(cpu_clks), .lb_valid(lb_valid), .lb_data(lb_data),
    .clr(flag_clr), .fail(lb_fail));

  assign drive_a = busy && !tx_shutdown && !cur_bus && bus_a_en;
  assign drive_b = busy && !tx_shutdown &&  cur_bus && bus_b_en;

  assign bus_a_p   = drive_a ? level  : 1'b1;
  assign bus_a_n   = drive_a ? ~level : 1'b1;
  assign bus_a_inh = ~drive_a;
  assign bus_b_p   = drive_b ? level  : 1'b1;
  assign bus_b_n   = drive_b ? ~level : 1'b1;
  assign bus_b_inh = ~drive_b;

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_a_p && bus_a_n && bus_b_p && bus_b_n && bus_a_inh && bus_b_inh));
  // R5
  pair_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_a_inh |-> (bus_a_p != bus_a_n)) and (!bus_b_inh |-> (bus_b_p != bus_b_n)));
  // R7
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shutdown |-> (bus_a_inh && bus_b_inh && !tx_ready));
endmodule

// File: tb/mbus_word_encoder_tb.sv
module mbus_word_encoder_tb;
  localparam int SD_US = 70;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] freq_sel = 2'd0;
  logic tx_valid = 1'b0, tx_is_cmd = 1'b0, tx_bus_sel = 1'b0;
  logic [15:0] tx_data = '0, lb_data = '0;
  logic bus_a_en = 1'b1, bus_b_en = 1'b1, lb_valid = 1'b0, flag_clr = 1'b0;
  logic tx_ready, bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh;
  logic tx_shutdown, lb_fail;

  int nvec = 0, nfail = 0;
  bit started = 0;
  logic [15:0] wd [8];
  logic        wc [8];
  int  lbd = 3;
  bit  lb_skip = 0, lb_corrupt = 0;

  always #10 clk = ~clk;

  mbus_word_encoder #(.SHUTDOWN_US(SD_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_is_cmd(tx_is_cmd),
    .tx_bus_sel(tx_bus_sel), .bus_a_en(bus_a_en), .bus_b_en(bus_b_en),
    .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_a_inh(bus_a_inh),
    .bus_b_p(bus_b_p), .bus_b_n(bus_b_n), .bus_b_inh(bus_b_inh),
    .tx_shutdown(tx_shutdown), .lb_valid(lb_valid), .lb_data(lb_data),
    .lb_fail(lb_fail), .flag_clr(flag_clr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hclk();
    return 6 + 2 * int'(freq_sel);
  endfunction

  // expected 40 half-bit levels, half 0 at bit 39
  function automatic logic [39:0] wave(input logic [15:0] d, input logic cmd);
    logic [39:0] v;
    int ones = 0;
    v[39:34] = cmd ? 6'b111000 : 6'b000111;
    for (int i = 0; i < 16; i++) begin
      v[33 - 2*i] = d[15 - i];
      v[32 - 2*i] = ~d[15 - i];
      ones += int'(d[15 - i]);
    end
    v[1] = (ones % 2 == 0);
    v[0] = ~v[1];
    return v;
  endfunction

  task automatic idle_check(input string req);
    chk({bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh} == 6'b111111,
        req, {bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh}, 6'b111111);
  endtask

  task automatic drive_words(input int n);
    started = 0;
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      tx_valid = 1'b1; tx_data = wd[w]; tx_is_cmd = wc[w];
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      if (w == 0) started = 1;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic lb_drive(input int t, input int w);
    if (t == lbd && !lb_skip) begin
      lb_valid = 1'b1;
      lb_data  = lb_corrupt ? (wd[w] ^ 16'h0010) : wd[w];
    end else lb_valid = 1'b0;
  endtask

  task automatic monitor(input int n);
    int H;
    logic [39:0] v;
    logic lvl, en;
    logic [5:0] got, exp;
    wait (started);
    H = hclk();
    for (int w = 0; w < n; w++) begin
      v = wave(wd[w], wc[w]);
      for (int t = 0; t < 40 * H; t++) begin
        @(negedge clk);
        if (w > 0) lb_drive(t, w - 1); else lb_valid = 1'b0;
        lvl = v[39 - t / H];
        en  = tx_bus_sel ? bus_b_en : bus_a_en;
        exp = tx_bus_sel ? {3'b111, en ? {lvl, ~lvl, 1'b0} : 3'b111}
                         : {en ? {lvl, ~lvl, 1'b0} : 3'b111, 3'b111};
        got = {bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh};
        chk(got == exp, (t / H < 6) ? "R1 R2 R5" : "R1 R3 R5", got, exp);
        if (t == 38 * H - 1) chk(tx_ready == 1'b0, "R6", tx_ready, 0);
        if (t == 38 * H)     chk(tx_ready == 1'b1, "R6", tx_ready, 1);
      end
    end
  endtask

  // sends n words, answers loopback lbd cycles after each word end
  task automatic stream(input int n, input bit exp_fail);
    int H;
    H = hclk();
    fork
      drive_words(n);
      monitor(n);
    join
    for (int t = 0; t <= 8 * H + 2; t++) begin
      @(negedge clk);
      lb_drive(t, n - 1);
      if (t == 0) idle_check("R4");
      if (t == 0) chk(tx_ready == 1'b1, "R6", tx_ready, 1);
      if (lb_skip && t == 8 * H - 1) chk(lb_fail == 1'b0, "R9", lb_fail, 0);
      if (lb_skip && t == 8 * H)     chk(lb_fail == 1'b1, "R9", lb_fail, 1);
    end
    chk(lb_fail == exp_fail, exp_fail ? "R9" : "R8", lb_fail, exp_fail);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R11");
    chk(tx_ready == 1'b1, "R11", tx_ready, 1);
    chk({tx_shutdown, lb_fail} == 2'b00, "R11", {tx_shutdown, lb_fail}, 0);

    // R1 R2 R3 R8: sweep every clock frequency, both word types
    for (int f = 0; f < 4; f++) begin
      freq_sel = 2'(f);
      wd[0] = 16'hA5A5; wc[0] = 1'b1;
      wd[1] = 16'h0000; wc[1] = 1'b0;
      wd[2] = 16'hFFFF; wc[2] = 1'b0;
      lbd = 3;
      stream(3, 1'b0);
    end

    // R5 R8: bus B, loopback in last cycle of window
    freq_sel = 2'd1; tx_bus_sel = 1'b1;
    wd[0] = 16'h8001; wc[0] = 1'b1;
    wd[1] = 16'h7FFE; wc[1] = 1'b0;
    lbd = 8 * hclk() - 1;
    stream(2, 1'b0);

    // R5: selected bus disabled keeps both buses idle
    tx_bus_sel = 1'b0; bus_a_en = 1'b0; lbd = 2;
    wd[0] = 16'h1234; wc[0] = 1'b0;
    stream(1, 1'b0);
    bus_a_en = 1'b1;

    // R9: mismatching loopback
    freq_sel = 2'd2; lb_corrupt = 1;
    wd[0] = 16'h0F0F; wc[0] = 1'b1;
    stream(1, 1'b1);
    lb_corrupt = 0;
    clear_flags();
    chk(lb_fail == 1'b0, "R9", lb_fail, 0);

    // R9: missing loopback, exact window edge
    freq_sel = 2'd0; lb_skip = 1;
    wd[0] = 16'hC3C3; wc[0] = 1'b0;
    stream(1, 1'b1);
    lb_skip = 0;
    clear_flags();

    // R10: stray loopback while no window is open
    @(negedge clk); lb_valid = 1'b1; lb_data = 16'hDEAD;
    @(negedge clk); lb_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(lb_fail == 1'b0, "R10", lb_fail, 0);

    // R7: continuous transmit watchdog at 12 MHz
    freq_sel = 2'd0;
    for (int w = 0; w < 4; w++) begin wd[w] = 16'h5555 + 16'(w); wc[w] = 1'b0; end
    begin
      int trip_t;
      trip_t = -1;
      fork
        drive_words(4);
        begin
          wait (started);
          for (int t = 0; t < 2000 && trip_t < 0; t++) begin
            @(negedge clk);
            if (tx_shutdown) trip_t = t;
          end
        end
      join
      chk(trip_t == SD_US * 12, "R7", trip_t, SD_US * 12);
    end
    @(negedge clk);
    idle_check("R7");
    chk(tx_ready == 1'b0, "R7", tx_ready, 0);
    repeat (20) @(negedge clk);
    chk(tx_shutdown == 1'b1, "R7", tx_shutdown, 1);
    clear_flags();
    chk(tx_shutdown == 1'b0, "R7", tx_shutdown, 0);
    chk(tx_ready == 1'b1, "R7", tx_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule